// File: doc/BRIEF.md
# Configuration Stream Sync and Command Decoder

This block sits at the head of a configuration loader and watches a byte stream arriving over a valid/ready handshake. It first hunts for the start of a bitstream: a long run of 0xFF bytes, two checksum bytes whose value does not matter, and a four-byte sync pattern. Once locked, it decodes the command sequence that precedes the configuration frames. Each command is an opcode byte followed by three option bytes, and some commands add a four-byte payload.

Opcodes are matched on their low seven bits, because bit 7 only marks that per-command CRC checking is off. The decoder latches device options, the decompressor's zero-run replacement keys, the flash address and the user code. It checks the device identifier against a parameter. When the frame-load command arrives, it hands the frame count and the CRC-enable flag to the downstream frame checker with a one-cycle strobe. It then stays out of the way until that checker signals that the frame section is over. An end command, a wrong identifier or an unknown opcode halts the stream until reset.

Top module: `cfg_cmd_parser`

## Requirements
- R1: During and just after reset, the block reports these values: `in_ready` is 1; all flags and the strobe are 0; `zero_keys` is 0xFFFFFF; every other output is 0.
- R2: `sync_locked` rises, and command decoding starts with the next byte, on the accepted 0xC3 byte under two conditions. The three bytes accepted just before it must be 0xFF, 0xFF, 0xA5. Before that, at least `MIN_FF` consecutive 0xFF bytes must have been accepted since reset. A 0xFF run is never restarted by an arbitrary checksum byte. Bytes accepted before lock are never decoded as commands.
- R3: A 0xFF byte in an opcode position is skipped. It changes no output, and the next byte is again taken as an opcode.
- R4: Opcode 0x10 (or 0x90) is 8 bytes long. Its last four bytes, most significant first, form a word W. The command latches `load_rate`=W[23:16], `compress_en`=W[13] and `done_bypass`=W[12].
- R5: Opcode 0x51 (or 0xD1) is 8 bytes long and latches `zero_keys`=W[23:0].
- R6: Opcode 0xD2 (low seven bits 0x52) is 8 bytes long and latches `flash_addr`=W.
- R7: Opcode 0x0A (or 0x8A) is 8 bytes long and latches `user_code`=W.
- R8: Opcode 0x06 (or 0x86) is 8 bytes long. If W differs from `EXP_ID`, `id_mismatch` is set sticky and `in_ready` drops until reset.
- R9: Opcode 0x0B (or 0x8B) is 4 bytes long and changes no output.
- R10: Opcode 0x3B (or 0xBB) is 4 bytes long; its three option bytes form O[23:0]. It latches `crc_en`=O[23] and `frame_count`=O[15:0], and pulses `frames_start` for exactly one cycle. Accepted bytes are then not decoded until a cycle with `frames_end` high, after which the next byte is an opcode.
- R11: Opcode 0x08 (or 0x88) is 4 bytes long. It sets `stream_done` and drops `in_ready` until reset.
- R12: Any other opcode sets `bad_opcode` sticky and drops `in_ready` until reset.
- R13: Each result appears in the clock cycle right after the edge that accepts the command's final byte (or the sync byte). When a halting command ends, `in_ready` is low from that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| frames_end | input | 1 | Frame checker finished the frame section |
| sync_locked | output | 1 | Preamble and sync recognised |
| crc_en | output | 1 | Frame CRC checking enabled |
| frame_count | output | 16 | Number of configuration frames |
| frames_start | output | 1 | One-cycle hand-off strobe to the frame checker |
| load_rate | output | 8 | Loading-rate code |
| compress_en | output | 1 | Compressed bitstream |
| done_bypass | output | 1 | Program-done bypass enabled |
| zero_keys | output | 24 | Replacement keys for 8, 4 and 2 zero bytes |
| flash_addr | output | 32 | Flash address |
| user_code | output | 32 | User code |
| id_mismatch | output | 1 | Device identifier mismatch, sticky |
| bad_opcode | output | 1 | Unknown opcode seen, sticky |
| stream_done | output | 1 | End command seen |

## Verification
Every result in this block is due one cycle after the edge that accepts its final byte. This covers the latched options, the strobe, the sticky flags and the drop of `in_ready`. The bench's behavioural model therefore advances on the same edge the design does, consuming exactly the bytes it predicts are accepted. All outputs are compared half a period later, on every cycle, so a result that arrives a cycle early or late, or a strobe that lasts two cycles, shows up as a mismatch. Stimulus mixes back-to-back bytes with idle gaps, so the checks do not depend on a fixed byte rhythm.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [2:0] {
        M_HUNT,
        M_CMD,
        M_FRAMES,
        M_DONE,
        M_ERR
    } mode_e;

    localparam logic [7:0]  PAD_BYTE   = 8'hFF;
    localparam logic [23:0] SYNC_HEAD  = 24'hFFFFA5;
    localparam logic [7:0]  SYNC_TAIL  = 8'hC3;

    // opcodes compared on their low seven bits
    localparam logic [6:0] OP_IDCHK  = 7'h06;
    localparam logic [6:0] OP_DEVOPT = 7'h10;
    localparam logic [6:0] OP_ZKEYS  = 7'h51;
    localparam logic [6:0] OP_SECURE = 7'h0B;
    localparam logic [6:0] OP_FLASH  = 7'h52;
    localparam logic [6:0] OP_LOAD   = 7'h3B;
    localparam logic [6:0] OP_USER   = 7'h0A;
    localparam logic [6:0] OP_END    = 7'h08;

    typedef struct packed {
        logic [6:0]  op;
        logic [31:0] arg;   // last four bytes of the command, first byte high
    } cmd_t;

    // total length in bytes, zero for an unknown opcode
    function automatic logic [3:0] cmd_bytes(input logic [6:0] op);
        case (op)
            OP_IDCHK, OP_DEVOPT, OP_ZKEYS, OP_FLASH, OP_USER: cmd_bytes = 4'd8;
            OP_SECURE, OP_LOAD, OP_END:                      cmd_bytes = 4'd4;
            default:                                         cmd_bytes = 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/cfg_sync_hunt.sv
module cfg_sync_hunt import cfgp_pkg::*; #(
    parameter int MIN_FF = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       fire,
    input  logic [7:0] byte_in,
    output logic       sync_hit
);
    localparam int CW = $clog2(MIN_FF + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(MIN_FF);

    logic [CW-1:0] run, run_nx;
    logic [23:0]   win;
    logic          armed;

    always_comb begin
        if (byte_in == PAD_BYTE)
            run_nx = (run == RUN_MAX) ? run : run + 1'b1;
        else
            run_nx = '0;
    end

    assign sync_hit = en && fire && armed && (win == SYNC_HEAD) && (byte_in == SYNC_TAIL);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run   <= '0;
            win   <= '0;
            armed <= 1'b0;
        end else if (fire) begin
            run <= run_nx;
            win <= {win[15:0], byte_in};
            if (run_nx == RUN_MAX)
                armed <= 1'b1;
        end
    end

    // R2: the sync byte can only be recognised after a long enough run
    a_r2_hit_needs_run: assert property (@(posedge clk) disable iff (rst)
        sync_hit |-> $past(en) && armed);

endmodule

// File: rtl/cfg_cmd_asm.sv
module cfg_cmd_asm import cfgp_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       fire,
    input  logic [7:0] byte_in,
    output logic       cmd_done,
    output logic       bad_op,
    output cmd_t       cmd
);
    logic [2:0]  idx;
    logic [6:0]  op_q;
    logic [23:0] sh;
    logic [6:0]  op_cur;
    logic [3:0]  len;
    logic        first, nop, last, take;

    always_comb begin
        first  = (idx == 3'd0);
        op_cur = first ? byte_in[6:0] : op_q;
        len    = cmd_bytes(op_cur);
        nop    = first && (byte_in == PAD_BYTE);
        last   = (({1'b0, idx} + 4'd1) == len);
        take   = en && fire && !nop;
    end

    assign bad_op   = take && (len == 4'd0);
    assign cmd_done = take && (len != 4'd0) && last;
    assign cmd.op   = op_cur;
    assign cmd.arg  = {sh, byte_in};

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            idx  <= '0;
            op_q <= '0;
            sh   <= '0;
        end else if (take && len != 4'd0) begin
            idx <= last ? 3'd0 : idx + 3'd1;
            if (first)
                op_q <= op_cur;
            sh <= {sh[15:0], byte_in};
        end
    end

    // R3: a pad byte at an opcode position neither completes nor faults
    a_r3_pad_skipped: assert property (@(posedge clk) disable iff (rst)
        (en && fire && idx == 3'd0 && byte_in == PAD_BYTE) |-> !cmd_done && !bad_op);

    // R12: an unknown opcode can only be seen at an opcode position
    a_r12_bad_at_start: assert property (@(posedge clk) disable iff (rst)
        bad_op |-> idx == 3'd0);

endmodule

// File: rtl/cfg_opt_regs.sv
module cfg_opt_regs import cfgp_pkg::*; #(
    parameter logic [31:0] EXP_ID = 32'h1100581B
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_done,
    input  cmd_t        cmd,
    output logic        id_bad,
    output logic        is_load,
    output logic        is_end,
    output logic        crc_en,
    output logic [15:0] frame_count,
    output logic [7:0]  load_rate,
    output logic        compress_en,
    output logic        done_bypass,
    output logic [23:0] zero_keys,
    output logic [31:0] flash_addr,
    output logic [31:0] user_code
);
    assign id_bad  = cmd_done && cmd.op == OP_IDCHK && cmd.arg != EXP_ID;
    assign is_load = cmd_done && cmd.op == OP_LOAD;
    assign is_end  = cmd_done && cmd.op == OP_END;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_en      <= 1'b0;
            frame_count <= '0;
            load_rate   <= '0;
            compress_en <= 1'b0;
            done_bypass <= 1'b0;
            zero_keys   <= '1;
            flash_addr  <= '0;
            user_code   <= '0;
        end else if (cmd_done) begin
            case (cmd.op)
                OP_DEVOPT: begin
                    load_rate   <= cmd.arg[23:16];
                    compress_en <= cmd.arg[13];
                    done_bypass <= cmd.arg[12];
                end
                OP_ZKEYS: zero_keys  <= cmd.arg[23:0];
                OP_FLASH: flash_addr <= cmd.arg;
                OP_USER:  user_code  <= cmd.arg;
                OP_LOAD: begin
                    crc_en      <= cmd.arg[23];
                    frame_count <= cmd.arg[15:0];
                end
                default: ;
            endcase
        end
    end

    // R9: the security marker leaves every option untouched
    a_r9_secure_inert: assert property (@(posedge clk) disable iff (rst)
        (cmd_done && cmd.op == OP_SECURE) |=> $stable(zero_keys) && $stable(user_code)
            && $stable(flash_addr) && $stable(load_rate) && $stable(frame_count));

endmodule

// File: rtl/cfg_cmd_parser.sv
module cfg_cmd_parser import cfgp_pkg::*; #(
    parameter int          MIN_FF = 16,
    parameter logic [31:0] EXP_ID = 32'h1100581B
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    input  logic        frames_end,
    output logic        sync_locked,
    output logic        crc_en,
    output logic [15:0] frame_count,
    output logic        frames_start,
    output logic [7:0]  load_rate,
    output logic        compress_en,
    output logic        done_bypass,
    output logic [23:0] zero_keys,
    output logic [31:0] flash_addr,
    output logic [31:0] user_code,
    output logic        id_mismatch,
    output logic        bad_opcode,
    output logic        stream_done
);
    mode_e mode, mode_nx;
    logic  fire, sync_hit, cmd_done, bad_op, id_bad, is_load, is_end;
    cmd_t  cmd;

    assign in_ready = (mode != M_DONE) && (mode != M_ERR);
    assign fire     = in_valid && in_ready;

    cfg_sync_hunt #(.MIN_FF(MIN_FF)) u_hunt (
        .clk(clk), .rst(rst), .en(mode == M_HUNT), .fire(fire),
        .byte_in(in_data), .sync_hit(sync_hit)
    );

    cfg_cmd_asm u_asm (
        .clk(clk), .rst(rst), .en(mode == M_CMD), .fire(fire),
        .byte_in(in_data), .cmd_done(cmd_done), .bad_op(bad_op), .cmd(cmd)
    );

    cfg_opt_regs #(.EXP_ID(EXP_ID)) u_regs (
        .clk(clk), .rst(rst), .cmd_done(cmd_done), .cmd(cmd),
        .id_bad(id_bad), .is_load(is_load), .is_end(is_end),
        .crc_en(crc_en), .frame_count(frame_count), .load_rate(load_rate),
        .compress_en(compress_en), .done_bypass(done_bypass),
        .zero_keys(zero_keys), .flash_addr(flash_addr), .user_code(user_code)
    );

    always_comb begin
        mode_nx = mode;
        case (mode)
            M_HUNT:   if (sync_hit) mode_nx = M_CMD;
            M_CMD: begin
                if (bad_op || id_bad) mode_nx = M_ERR;
                else if (is_load)     mode_nx = M_FRAMES;
                else if (is_end)      mode_nx = M_DONE;
            end
            M_FRAMES: if (frames_end) mode_nx = M_CMD;
            default:  mode_nx = mode;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode         <= M_HUNT;
            sync_locked  <= 1'b0;
            frames_start <= 1'b0;
            id_mismatch  <= 1'b0;
            bad_opcode   <= 1'b0;
            stream_done  <= 1'b0;
        end else begin
            mode         <= mode_nx;
            frames_start <= is_load;
            if (sync_hit) sync_locked <= 1'b1;
            if (id_bad)   id_mismatch <= 1'b1;
            if (bad_op)   bad_opcode  <= 1'b1;
            if (is_end)   stream_done <= 1'b1;
        end
    end

    // R10: hand-off strobe lasts one cycle and leaves decoding parked
    a_r10_start_pulse: assert property (@(posedge clk) disable iff (rst)
        frames_start |=> !frames_start);
    a_r10_start_parks: assert property (@(posedge clk) disable iff (rst)
        frames_start |-> mode == M_FRAMES || mode == M_CMD);
    // R8: identifier fault is sticky and stalls the stream
    a_r8_id_sticky: assert property (@(posedge clk) disable iff (rst)
        id_mismatch |=> id_mismatch && !in_ready);
    // R12: opcode fault is sticky
    a_r12_bad_sticky: assert property (@(posedge clk) disable iff (rst)
        bad_opcode |=> bad_opcode && !in_ready);
    // R11: end of stream stalls input
    a_r11_done_halts: assert property (@(posedge clk) disable iff (rst)
        stream_done |-> !in_ready);
    // R2: lock never falls back
    a_r2_lock_holds: assert property (@(posedge clk) disable iff (rst)
        sync_locked |=> sync_locked);

endmodule

// File: tb/cfg_cmd_parser_tb.sv
module cfg_cmd_parser_tb;
    localparam int          MIN_FF = 16;
    localparam logic [31:0] EXP_ID = 32'h1100581B;

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 1'b0, frames_end = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, sync_locked, crc_en, frames_start, compress_en, done_bypass;
    logic id_mismatch, bad_opcode, stream_done;
    logic [15:0] frame_count;
    logic [7:0]  load_rate;
    logic [23:0] zero_keys;
    logic [31:0] flash_addr, user_code;

    always #10 clk = ~clk;

    cfg_cmd_parser #(.MIN_FF(MIN_FF), .EXP_ID(EXP_ID)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .frames_end(frames_end), .sync_locked(sync_locked),
        .crc_en(crc_en), .frame_count(frame_count), .frames_start(frames_start),
        .load_rate(load_rate), .compress_en(compress_en), .done_bypass(done_bypass),
        .zero_keys(zero_keys), .flash_addr(flash_addr), .user_code(user_code),
        .id_mismatch(id_mismatch), .bad_opcode(bad_opcode), .stream_done(stream_done)
    );

    // ---------------- reference model ----------------
    int   m_mode;          // 0 hunt, 1 commands, 2 frames, 3 done, 4 error
    int   m_run;
    bit   m_armed;
    logic [7:0] hq[$];
    logic [7:0] cq[$];
    logic m_lock, m_crc, m_fs, m_comp, m_byp, m_idbad, m_bad, m_done;
    logic [15:0] m_cnt;
    logic [7:0]  m_rate;
    logic [23:0] m_keys;
    logic [31:0] m_flash, m_user;

    int compared = 0, mismatched = 0, cyc = 0;
    string scen = "R1 reset";

    function automatic int op_len(input logic [7:0] o);
        case (o & 8'h7F)
            8'h06, 8'h10, 8'h51, 8'h52, 8'h0A: return 8;
            8'h0B, 8'h3B, 8'h08:               return 4;
            default:                           return 0;
        endcase
    endfunction

    task automatic model_reset();
        m_mode = 0; m_run = 0; m_armed = 0; hq.delete(); cq.delete();
        m_lock = 0; m_crc = 0; m_fs = 0; m_comp = 0; m_byp = 0;
        m_idbad = 0; m_bad = 0; m_done = 0; m_cnt = 0; m_rate = 0;
        m_keys = 24'hFFFFFF; m_flash = 0; m_user = 0;
    endtask

    task automatic model_exec();
        int n = cq.size();
        logic [31:0] w = {cq[n-4], cq[n-3], cq[n-2], cq[n-1]};
        case (cq[0] & 8'h7F)
            8'h06: if (w != EXP_ID) begin m_idbad = 1; m_mode = 4; end
            8'h10: begin m_rate = w[23:16]; m_comp = w[13]; m_byp = w[12]; end
            8'h51: m_keys = w[23:0];
            8'h52: m_flash = w;
            8'h0A: m_user = w;
            8'h3B: begin m_crc = w[23]; m_cnt = w[15:0]; m_fs = 1; m_mode = 2; end
            8'h08: begin m_done = 1; m_mode = 3; end
            default: ;
        endcase
        cq.delete();
    endtask

    task automatic model_byte(input logic [7:0] b);
        if (m_mode == 0) begin
            int s = hq.size();
            if (b == 8'hC3 && m_armed && s >= 3 && hq[s-3] == 8'hFF && hq[s-2] == 8'hFF
                && hq[s-1] == 8'hA5) begin
                m_mode = 1; m_lock = 1;
            end else begin
                m_run = (b == 8'hFF) ? m_run + 1 : 0;
                if (m_run >= MIN_FF) m_armed = 1;
                hq.push_back(b);
            end
        end else if (m_mode == 1) begin
            if (cq.size() == 0 && b == 8'hFF) return;
            cq.push_back(b);
            if (op_len(cq[0]) == 0) begin
                m_bad = 1; m_mode = 4; cq.delete();
            end else if (cq.size() == op_len(cq[0])) begin
                model_exec();
            end
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) model_reset();
        else begin
            m_fs = 0;
            if (m_mode == 2) begin
                if (frames_end) m_mode = 1;
            end else if (in_valid && m_mode < 3) begin
                model_byte(in_data);
            end
        end
        if (cyc > 150000) begin
            mismatched++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s [%s] at %0t: actual 0x%0h expected 0x%0h", tag, scen, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cyc > 0) begin
            check("R13 R8 R11 R12 in_ready", {31'd0, in_ready}, {31'd0, m_mode < 3});
            check("R2 sync_locked", {31'd0, sync_locked}, {31'd0, m_lock});
            check("R10 crc_en", {31'd0, crc_en}, {31'd0, m_crc});
            check("R10 frame_count", {16'd0, frame_count}, {16'd0, m_cnt});
            check("R10 frames_start", {31'd0, frames_start}, {31'd0, m_fs});
            check("R4 load_rate", {24'd0, load_rate}, {24'd0, m_rate});
            check("R4 compress_en", {31'd0, compress_en}, {31'd0, m_comp});
            check("R4 done_bypass", {31'd0, done_bypass}, {31'd0, m_byp});
            check("R5 zero_keys", {8'd0, zero_keys}, {8'd0, m_keys});
            check("R6 flash_addr", flash_addr, m_flash);
            check("R7 user_code", user_code, m_user);
            check("R8 id_mismatch", {31'd0, id_mismatch}, {31'd0, m_idbad});
            check("R12 bad_opcode", {31'd0, bad_opcode}, {31'd0, m_bad});
            check("R11 stream_done", {31'd0, stream_done}, {31'd0, m_done});
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input logic [7:0] b);
        in_valid = 1'b1; in_data = b;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic send_bytes(input logic [7:0] b[$]);
        foreach (b[i]) begin
            send(b[i]);
            if (i % 3 == 2) idle(1);
        end
    endtask

    task automatic preamble(input int nff);
        for (int i = 0; i < nff; i++) send(8'hFF);
        send_bytes('{8'h12, 8'h34, 8'hFF, 8'hFF, 8'hA5, 8'hC3});
    endtask

    task automatic do_reset();
        rst = 1'b1; idle(3); rst = 1'b0; idle(1);
    endtask

    initial begin
        #1;
        idle(3);
        rst = 1'b0;
        idle(1);

        // Run A: full legal stream
        scen = "R2 bytes before lock ignored";
        send_bytes('{8'h10, 8'h44, 8'hA5, 8'hC3});
        scen = "R2 preamble";
        preamble(20);
        idle(2);
        scen = "R3 pad opcodes";
        send_bytes('{8'hFF, 8'hFF});
        scen = "R8 matching id";
        send_bytes('{8'h06, 8'h00, 8'h00, 8'h00, 8'h11, 8'h00, 8'h58, 8'h1B});
        scen = "R4 device options, crc-off form";
        send_bytes('{8'h90, 8'h00, 8'h00, 8'h00, 8'h00, 8'h5A, 8'h30, 8'h00});
        scen = "R5 zero keys";
        send_bytes('{8'h51, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h12, 8'h34, 8'h56});
        scen = "R9 security marker";
        send_bytes('{8'h8B, 8'h00, 8'h00, 8'h00});
        scen = "R6 flash address";
        send_bytes('{8'hD2, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h01, 8'h02, 8'h03});
        scen = "R10 frame load";
        send_bytes('{8'hBB, 8'h80, 8'h02, 8'hC8});
        send_bytes('{8'h77, 8'h77, 8'h06, 8'h00, 8'hFF});
        idle(2);
        frames_end = 1'b1; @(posedge clk); #1; frames_end = 1'b0;
        scen = "R7 user code";
        send_bytes('{8'h0A, 8'h00, 8'h00, 8'h00, 8'hDE, 8'hAD, 8'hBE, 8'hEF});
        scen = "R11 end of stream";
        send_bytes('{8'h08, 8'h00, 8'h00, 8'h00});
        send_bytes('{8'h44, 8'h10, 8'h00});
        idle(3);

        // Run B: identifier mismatch
        scen = "R1 reset after run";
        do_reset();
        preamble(18);
        scen = "R8 wrong id";
        send_bytes('{8'h86, 8'h00, 8'h00, 8'h00, 8'h09, 8'h00, 8'h28, 8'h1B});
        send_bytes('{8'h0A, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h03, 8'h04});
        idle(3);

        // Run C: short run does not lock, then load without CRC, then unknown opcode
        scen = "R1 reset";
        do_reset();
        scen = "R2 short pad run";
        preamble(3);
        idle(2);
        scen = "R2 relock";
        preamble(MIN_FF);
        scen = "R10 load crc off";
        send_bytes('{8'h3B, 8'h00, 8'h00, 8'h05});
        idle(2);
        frames_end = 1'b1; @(posedge clk); #1; frames_end = 1'b0;
        scen = "R12 unknown opcode";
        send_bytes('{8'hFF, 8'h44, 8'h00, 8'h00, 8'h00});
        idle(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule